// File: doc/BRIEF.md
# Peripheral Interrupt Priority Mapper

This block sits between fifteen peripheral interrupt request lines and the user-assignable part of a core interrupt latch. Each source owns a small priority register. A request from a source lights the latch position that matches the source's current priority. Priority 0 is the most urgent and lands on bit 4. Priority 11 is the least urgent and lands on bit 15. Any number of sources may hold the same priority. Their requests are then ORed onto one shared latch bit, so they also share that bit's vector.

At reset, source `n` takes priority `n` for `n` up to 11. Sources 12, 13 and 14 saturate at 11, so they sit on bit 15 beside source 11. Software changes the mapping through a plain synchronous register port, with one write strobe and one read strobe. Any priority written above 11 is stored as 11. The request path from `src_req` to `irq_vec` is purely combinational. Only a priority update waits for a clock edge. No payload streams through the block, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure.

Top module: `irq_prio_map`

## Requirements
- R1: After reset, reading source `n` returns `n` for `n` in 0..11 and returns 11 for sources 12, 13 and 14.
- R2: While `src_req[s]` is high, `irq_vec` bit `4 + p` is high, where `p` is the priority currently stored for source `s`. This happens in the same cycle, with no register on the path.
- R3: Sources that hold the same priority are ORed onto a single `irq_vec` bit. No other bit is set by them.
- R4: `irq_vec[3:0]` is zero at all times.
- R5: A write whose 4-bit data exceeds 11 stores 11.
- R6: A write with `cfg_we` high and `cfg_addr` in 0..14 updates that source's priority at the clock edge. The new routing and the new read value are visible from the next cycle.
- R7: A read with `cfg_re` high loads `cfg_rdata` at the clock edge. `cfg_rdata` holds its value while `cfg_re` is low. If a read and a write hit the same address in the same cycle, the read returns the value held before the write.
- R8: Addresses 15 and above are unmapped. A write there changes no priority, and a read there returns 0.
- R9: With no request active, `irq_vec` is all zero. `cfg_rdata` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the priority registers |
| cfg_re | input | 1 | Read strobe for the priority registers |
| cfg_addr | input | 4 | Source index for the read or the write |
| cfg_wdata | input | 4 | Priority to write (clamped to 11) |
| cfg_rdata | output | 4 | Registered read data |
| src_req | input | 15 | Peripheral request lines, bit = source index |
| irq_vec | output | 16 | Request vector toward the core latch, bits 4..15 used |

## Verification
The bench provokes two collisions within one clock. In the first, a write and a read target the same source in the same cycle. The read must return the old priority, and a second read must return the new one. In the second, a priority is rewritten while that source's request is held high. The vector is sampled after the edge and must show the request moved to its new bit. Shared levels are judged by driving several sources that collide onto one bit and checking that exactly that bit is set.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

  // Default priority of a source after reset: its own index, saturated.
  function automatic int reset_level(input int id, input int max_lvl);
    return (id > max_lvl) ? max_lvl : id;
  endfunction

  // Saturate a written priority at the least urgent level.
  function automatic logic [3:0] clamp_level(input logic [3:0] v, input logic [3:0] max_v);
    return (v > max_v) ? max_v : v;
  endfunction

endpackage

// File: rtl/prio_regfile.sv
module prio_regfile
  import irq_map_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int PRIO_W  = 4,
  parameter int MAX_LVL = 11,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [PRIO_W-1:0]         wdata,
  output logic [PRIO_W-1:0]         rdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SRC - 1);
  localparam logic [PRIO_W-1:0] MAX_P     = PRIO_W'(MAX_LVL);

  logic              addr_ok;
  logic [PRIO_W-1:0] wclamp;
  logic [PRIO_W-1:0] rd_sel;

  assign addr_ok = (addr <= LAST_ADDR);
  assign wclamp  = (wdata > MAX_P) ? MAX_P : wdata;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    localparam logic [PRIO_W-1:0] RST_P = PRIO_W'(reset_level(s, MAX_LVL));
    logic              hit;
    logic [PRIO_W-1:0] prio_q;

    assign hit = we && addr_ok && (addr == ADDR_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_q <= RST_P;
      else if (hit) prio_q <= wclamp;
    end

    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q;
  end

  always_comb begin
    rd_sel = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == ADDR_W'(s)) rd_sel = prio_flat[s*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= addr_ok ? rd_sel : '0;
  end

endmodule

// File: rtl/src_level_decode.sv
module src_level_decode #(
  parameter int PRIO_W  = 4,
  parameter int NUM_LVL = 12
) (
  input  logic               req,
  input  logic [PRIO_W-1:0]  prio,
  output logic [NUM_LVL-1:0] hot
);

  always_comb begin
    hot = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (req && (prio == PRIO_W'(l))) hot[l] = 1'b1;
    end
  end

endmodule

// File: rtl/level_merge.sv
module level_merge #(
  parameter int NUM_SRC = 15,
  parameter int NUM_LVL = 12
) (
  input  logic [NUM_SRC*NUM_LVL-1:0] hot_flat,
  output logic [NUM_LVL-1:0]         lvl_req
);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_comb begin
      lvl_req[l] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        lvl_req[l] = lvl_req[l] | hot_flat[s*NUM_LVL + l];
      end
    end
  end

endmodule

// File: rtl/irq_prio_map.sv
module irq_prio_map #(
  parameter int NUM_SRC  = 15,
  parameter int PRIO_W   = 4,
  parameter int NUM_LVL  = 12,
  parameter int LVL_BASE = 4,
  parameter int ADDR_W   = 4,
  localparam int VEC_W   = LVL_BASE + NUM_LVL,
  localparam int MAX_LVL = NUM_LVL - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [PRIO_W-1:0]  cfg_wdata,
  output logic [PRIO_W-1:0]  cfg_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [VEC_W-1:0]   irq_vec
);

  logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
  logic [NUM_SRC*NUM_LVL-1:0] hot_flat;
  logic [NUM_LVL-1:0]         lvl_req;

  prio_regfile #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MAX_LVL(MAX_LVL), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .re(cfg_re),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .prio_flat(prio_flat)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
    src_level_decode #(.PRIO_W(PRIO_W), .NUM_LVL(NUM_LVL)) u_dec (
      .req (src_req[s]),
      .prio(prio_flat[s*PRIO_W +: PRIO_W]),
      .hot (hot_flat[s*NUM_LVL +: NUM_LVL])
    );
  end

  level_merge #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_merge (
    .hot_flat(hot_flat),
    .lvl_req (lvl_req)
  );

  // Lower latch positions are owned by non-peripheral events: tie off.
  assign irq_vec = {lvl_req, {LVL_BASE{1'b0}}};

endmodule

// File: rtl/irq_prio_map_chk.sv
module irq_prio_map_chk #(
  parameter int NUM_SRC  = 15,
  parameter int PRIO_W   = 4,
  parameter int NUM_LVL  = 12,
  parameter int LVL_BASE = 4,
  parameter int ADDR_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic                      cfg_re,
  input logic [ADDR_W-1:0]         cfg_addr,
  input logic [PRIO_W-1:0]         cfg_wdata,
  input logic [PRIO_W-1:0]         cfg_rdata,
  input logic [NUM_SRC-1:0]        src_req,
  input logic [LVL_BASE+NUM_LVL-1:0] irq_vec,
  input logic [NUM_SRC*PRIO_W-1:0] prio_flat
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SRC - 1);
  localparam logic [PRIO_W-1:0] MAX_P     = PRIO_W'(NUM_LVL - 1);

  function automatic logic [PRIO_W-1:0] pick(input logic [NUM_SRC*PRIO_W-1:0] flat,
                                             input logic [ADDR_W-1:0] a);
    logic [PRIO_W-1:0] r;
    r = '0;
    for (int s = 0; s < NUM_SRC; s++) if (a == ADDR_W'(s)) r = flat[s*PRIO_W +: PRIO_W];
    return r;
  endfunction

  logic              addr_ok;
  logic [PRIO_W-1:0] sel_prio;
  logic [PRIO_W-1:0] exp_w;

  assign addr_ok  = (cfg_addr <= LAST_ADDR);
  assign sel_prio = pick(prio_flat, cfg_addr);
  assign exp_w    = (cfg_wdata > MAX_P) ? MAX_P : cfg_wdata;

  assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[LVL_BASE-1:0] == '0);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == '0) |-> (irq_vec == '0));

  assert_fanin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_vec) <= $countones(src_req));

  assert_write_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && addr_ok) |=> (pick(prio_flat, $past(cfg_addr)) == $past(exp_w)));

  assert_read_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && addr_ok) |=> (cfg_rdata == $past(sel_prio)));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_re |=> $stable(cfg_rdata));

  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && !addr_ok) |=> (cfg_rdata == '0));

  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !addr_ok) |=> $stable(prio_flat));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_req[s] |-> irq_vec[LVL_BASE + int'(prio_flat[s*PRIO_W +: PRIO_W])]);
  end

endmodule

bind irq_prio_map irq_prio_map_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_LVL(NUM_LVL),
  .LVL_BASE(LVL_BASE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .src_req(src_req), .irq_vec(irq_vec), .prio_flat(prio_flat)
);

// File: tb/sim_irq_prio_map.sv
module sim_irq_prio_map;
  localparam int NS   = 15;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_re = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic [14:0] src_req = '0;
  logic [15:0] irq_vec;

  int errs = 0;
  int checks = 0;
  int model [NS];
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_map u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_req(src_req), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [14:0] req);
    logic [15:0] v;
    v = '0;
    for (int s = 0; s < NS; s++) if (req[s]) v[BASE + model[s]] = 1'b1;
    return v;
  endfunction

  task automatic do_write(input int a, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 4'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NS) model[a] = (w > 11) ? 11 : w;
  endtask

  task automatic do_read(input int a, output logic [3:0] r);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = 4'(a);
    @(negedge clk);
    cfg_re = 1'b0;
    r = cfg_rdata;
  endtask

  task automatic drive_req(input logic [14:0] r);
    src_req = r;
    #1;
  endtask

  task automatic t_reset();
    logic [3:0] r;
    #1;
    chk("R9 rdata in reset", 32'(cfg_rdata), 32'h0);
    chk("R9 vec idle in reset", 32'(irq_vec), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++) begin
      do_read(s, r);
      chk($sformatf("R1 reset prio src%0d", s), 32'(r), 32'((s > 11) ? 11 : s));
    end
    drive_req('1);
    chk("R4 low bits zero all req", 32'(irq_vec[3:0]), 32'h0);
    chk("R3 all req default", 32'(irq_vec), 32'(exp_vec('1)));
    drive_req('0);
    chk("R9 idle vec", 32'(irq_vec), 32'h0);
  endtask

  task automatic t_single();
    for (int s = 0; s < NS; s++) begin
      drive_req(15'(1) << s);
      chk($sformatf("R2 single src%0d", s), 32'(irq_vec), 32'(exp_vec(15'(1) << s)));
    end
    drive_req('0);
  endtask

  task automatic t_shared();
    drive_req(15'h7000);
    chk("R3 sources 12-14 share bit15", 32'(irq_vec), 32'h8000);
    drive_req(15'h4800);
    chk("R3 src11 and src14 share bit15", 32'(irq_vec), 32'h8000);
    drive_req('0);
  endtask

  task automatic t_rewrite();
    logic [3:0] r;
    do_write(3, 9);
    do_read(3, r);
    chk("R6 readback src3", 32'(r), 32'd9);
    drive_req(15'h0008);
    chk("R6 src3 routes bit13", 32'(irq_vec), 32'h2000);
    drive_req('0);
    do_write(12, 0);
    drive_req(15'h1001);
    chk("R3 src0 and src12 share bit4", 32'(irq_vec), 32'h0010);
    drive_req('0);
    // Rewrite while the request is held: new bit from the next cycle.
    drive_req(15'h0004);
    chk("R2 src2 before move", 32'(irq_vec), 32'h0040);
    do_write(2, 7);
    chk("R6 src2 moved while active", 32'(irq_vec), 32'(exp_vec(15'h0004)));
    chk("R6 src2 on bit11", 32'(irq_vec), 32'h0800);
    drive_req('0);
  endtask

  task automatic t_clamp();
    logic [3:0] r;
    do_write(5, 15);
    do_read(5, r);
    chk("R5 write 15 clamps", 32'(r), 32'd11);
    do_write(6, 12);
    do_read(6, r);
    chk("R5 write 12 clamps", 32'(r), 32'd11);
    drive_req(15'h0060);
    chk("R5 clamped route bit15", 32'(irq_vec), 32'h8000);
    drive_req('0);
  endtask

  task automatic t_bad_addr();
    logic [3:0] r;
    do_write(15, 0);
    do_read(15, r);
    chk("R8 unmapped read zero", 32'(r), 32'h0);
    for (int s = 0; s < NS; s++) begin
      do_read(s, r);
      chk($sformatf("R8 src%0d unchanged", s), 32'(r), 32'(model[s]));
    end
    drive_req('1);
    chk("R8 routing unchanged", 32'(irq_vec), 32'(exp_vec('1)));
    drive_req('0);
  endtask

  task automatic t_same_cycle();
    logic [3:0] r;
    int old;
    old = model[7];
    @(negedge clk);
    cfg_we = 1'b1; cfg_re = 1'b1; cfg_addr = 4'd7; cfg_wdata = 4'd2;
    @(negedge clk);
    cfg_we = 1'b0; cfg_re = 1'b0;
    model[7] = 2;
    chk("R7 same-cycle read returns old", 32'(cfg_rdata), 32'(old));
    @(negedge clk);
    chk("R7 rdata held without strobe", 32'(cfg_rdata), 32'(old));
    do_read(7, r);
    chk("R6 later read returns new", 32'(r), 32'd2);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) model[s] = (s > 11) ? 11 : s;
    t_reset();
    t_single();
    t_shared();
    t_rewrite();
    t_clamp();
    t_bad_addr();
    t_same_cycle();
    t_single();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule